// File: doc/BRIEF.md
# Two-Level Descriptor Walking DMA Channel

This block is a single copy channel driven by a short register window. Software queues a command word whose top three bits choose the command kind and whose low 29 bits give an 8-byte-aligned table address. The channel then walks two levels of memory structures. The outer level is a table of 32-bit entries, each naming an array of four-word copy descriptors. The inner level is that array, where each descriptor moves a byte count, rounded up to whole 32-bit words, from a source area to a destination area. An end flag in each table entry and in each descriptor command word stops the walk at the right place.

When a walk ends, the channel can push a status word into a small result queue. Software pops that queue by reading the result register. A status register shows how many results and how many queued commands are waiting, and a level interrupt follows the result queue. A flush register abandons the running walk at the next descriptor boundary. Memory is reached through one word-addressed request/acknowledge port with one request in flight.

The walker is a seven-state machine: IDLE (take a queued command), PTR (fetch a table entry), DESC (fetch the four descriptor words), CPRD (read one source word), CPWR (write it to the destination), NEXT (choose flush, next descriptor, next table entry or completion) and RSLT (push the result word, stalling while the queue is full). The transitions are: IDLE to PTR on a valid table command, and IDLE to RSLT on any other command kind. PTR goes to DESC. DESC goes to CPRD, to NEXT for a zero length, or to RSLT on a bad descriptor mode. CPRD goes to CPWR. CPWR goes back to CPRD while words remain, and to NEXT after the last word. NEXT goes to DESC, PTR or RSLT. RSLT goes to IDLE.

Top module: `dma_list_chan`

## Requirements
- R1: After reset the status register reads 0x00000001, a result read returns 0, irq is low and no memory request is raised.
- R2: A write to the command register (offset 0) whose bits 31:29 equal 1 starts a walk of the table at byte address bits[28:0] times 8.
- R3: Each table entry names a descriptor array at byte address entry[28:0] times 8. Entry bit 31 set makes it the final entry, and the walk otherwise continues with the next consecutive table word.
- R4: A descriptor is four consecutive words: command, source byte address, destination byte address and byte length. Bit 31 of the command word marks the final descriptor of its array, and the next descriptor otherwise starts 16 bytes later.
- R5: A descriptor copies ceil(length/4) words from increasing source word addresses to increasing destination word addresses. A length of 0 copies nothing, and the word just past the copied range is left untouched.
- R6: A descriptor whose command bits 1:0 are not 0, or a command whose bits 31:29 are not 1, pushes result 0x80000008 whatever the configuration, and ends the walk with no further copying.
- R7: A completed walk pushes result 0x80000002 when configuration bit 2 (offset 3) is set, and pushes nothing when it is clear.
- R8: A write to the flush register (offset 4) during a walk lets the current descriptor finish and then ends the walk. It pushes 0x80000004 when configuration bit 1 is set, and nothing otherwise.
- R9: Reading the result register (offset 1) returns and removes the oldest result. With the queue empty it returns 0 and changes nothing.
- R10: The status register (offset 2) holds the result count in bits 31:29, the queued command count in bits 28:27, a result-present flag in bit 1 and a command-space flag in bit 0. A command write is discarded when the two-entry command queue is full.
- R11: irq is high exactly when configuration bit 0 is set and the result queue is not empty.
- R12: While the four-entry result queue is full, the walker waits in RSLT, and no result is lost.
- R13: A memory request keeps mem_req, mem_we, mem_addr and mem_wdata unchanged until the cycle in which mem_ack is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; pops the result queue at offset 1 |
| reg_addr | input | 3 | Register offset: 0 command, 1 result, 2 status, 3 config, 4 flush |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq | output | 1 | Level interrupt |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | MEM_AW | Memory word address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted this cycle; read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
A wrong walker state shows up at the ports within the same walk. A bad word count or a bad address step leaves a destination word copied when it should not be, or missing when it should be there, as soon as that descriptor finishes. A wrong choice in NEXT either ends the walk early or runs past an end flag, and the result word and the untouched areas show this right after. A result queue that loses its count shows up on the next status read or on the next result pop. The sweeps over lengths, descriptor modes, command codes and queue fill levels compare memory and register values against expectations that the bench computes itself.

// File: rtl/dma_list_pkg.sv
package dma_list_pkg;

    typedef enum logic [2:0] {
        W_IDLE,
        W_PTR,
        W_DESC,
        W_CPRD,
        W_CPWR,
        W_NEXT,
        W_RSLT
    } walk_st_t;

    localparam logic [2:0]  KIND_TABLE = 3'd1;
    localparam logic [31:0] RES_ERR    = 32'h8000_0008;
    localparam logic [31:0] RES_FLUSH  = 32'h8000_0004;
    localparam logic [31:0] RES_DONE   = 32'h8000_0002;

    localparam logic [2:0] OFS_CMD   = 3'd0;
    localparam logic [2:0] OFS_RES   = 3'd1;
    localparam logic [2:0] OFS_STAT  = 3'd2;
    localparam logic [2:0] OFS_CFG   = 3'd3;
    localparam logic [2:0] OFS_FLUSH = 3'd4;

endpackage

// File: rtl/dma_fifo.sv
module dma_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           push,
    input  logic [W-1:0]                   din,
    input  logic                           pop,
    output logic [W-1:0]                   dout,
    output logic                           full,
    output logic                           empty,
    output logic [$clog2(DEPTH+1)-1:0]     count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  store [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = store[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) store[wr_ptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    // R10 / R12: writers must never offer data to a full queue
    p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

endmodule

// File: rtl/dma_walker.sv
module dma_walker
    import dma_list_pkg::*;
#(
    parameter int MEM_AW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_empty,
    input  logic [31:0]       cmd_word,
    output logic              cmd_pop,
    input  logic              res_full,
    output logic              res_push,
    output logic [31:0]       res_word,
    input  logic [1:0]        res_cfg,
    input  logic              flush_wr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata
);
    localparam int LW = 31;

    walk_st_t          state;
    logic [MEM_AW-1:0] ptr_wa, desc_wa, cp_src, cp_dst;
    logic [1:0]        idx;
    logic              d_last, last_ptr, flush_pend, rs_en;
    logic [1:0]        d_mode;
    logic [LW-1:0]     words_left;
    logic [31:0]       data_buf, rs_word;
    logic [32:0]       len_up;
    logic [LW-1:0]     nwords;

    assign len_up = {1'b0, mem_rdata} + 33'd3;
    assign nwords = len_up[32:2];

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= W_IDLE;
            ptr_wa     <= '0;
            desc_wa    <= '0;
            cp_src     <= '0;
            cp_dst     <= '0;
            idx        <= '0;
            d_last     <= 1'b0;
            d_mode     <= '0;
            last_ptr   <= 1'b0;
            flush_pend <= 1'b0;
            rs_en      <= 1'b0;
            rs_word    <= '0;
            words_left <= '0;
            data_buf   <= '0;
        end else begin
            unique case (state)
                W_IDLE: begin
                    if (flush_pend) begin
                        flush_pend <= 1'b0;
                    end else if (!cmd_empty) begin
                        if (cmd_word[31:29] == KIND_TABLE) begin
                            ptr_wa <= MEM_AW'({cmd_word[28:0], 1'b0});
                            state  <= W_PTR;
                        end else begin
                            rs_word <= RES_ERR;
                            rs_en   <= 1'b1;
                            state   <= W_RSLT;
                        end
                    end
                end
                W_PTR: begin
                    if (mem_ack) begin
                        last_ptr <= mem_rdata[31];
                        desc_wa  <= MEM_AW'({mem_rdata[28:0], 1'b0});
                        ptr_wa   <= ptr_wa + 1'b1;
                        idx      <= '0;
                        state    <= W_DESC;
                    end
                end
                W_DESC: begin
                    if (mem_ack) begin
                        idx <= idx + 1'b1;
                        unique case (idx)
                            2'd0: begin
                                d_last <= mem_rdata[31];
                                d_mode <= mem_rdata[1:0];
                            end
                            2'd1: cp_src <= MEM_AW'(mem_rdata[31:2]);
                            2'd2: cp_dst <= MEM_AW'(mem_rdata[31:2]);
                            default: begin
                                if (d_mode != 2'd0) begin
                                    rs_word <= RES_ERR;
                                    rs_en   <= 1'b1;
                                    state   <= W_RSLT;
                                end else begin
                                    words_left <= nwords;
                                    state      <= (nwords == '0) ? W_NEXT : W_CPRD;
                                end
                            end
                        endcase
                    end
                end
                W_CPRD: begin
                    if (mem_ack) begin
                        data_buf <= mem_rdata;
                        cp_src   <= cp_src + 1'b1;
                        state    <= W_CPWR;
                    end
                end
                W_CPWR: begin
                    if (mem_ack) begin
                        cp_dst     <= cp_dst + 1'b1;
                        words_left <= words_left - 1'b1;
                        state      <= (words_left == LW'(1)) ? W_NEXT : W_CPRD;
                    end
                end
                W_NEXT: begin
                    if (flush_pend) begin
                        flush_pend <= 1'b0;
                        rs_word    <= RES_FLUSH;
                        rs_en      <= res_cfg[0];
                        state      <= W_RSLT;
                    end else if (d_last) begin
                        if (last_ptr) begin
                            rs_word <= RES_DONE;
                            rs_en   <= res_cfg[1];
                            state   <= W_RSLT;
                        end else begin
                            state <= W_PTR;
                        end
                    end else begin
                        desc_wa <= desc_wa + MEM_AW'(4);
                        idx     <= '0;
                        state   <= W_DESC;
                    end
                end
                W_RSLT: begin
                    if (!rs_en || !res_full) state <= W_IDLE;
                end
                default: state <= W_IDLE;
            endcase
            if (flush_wr) flush_pend <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = data_buf;
        cmd_pop   = 1'b0;
        res_push  = 1'b0;
        res_word  = rs_word;
        unique case (state)
            W_IDLE: cmd_pop = !flush_pend && !cmd_empty;
            W_PTR: begin
                mem_req  = 1'b1;
                mem_addr = ptr_wa;
            end
            W_DESC: begin
                mem_req  = 1'b1;
                mem_addr = desc_wa + MEM_AW'(idx);
            end
            W_CPRD: begin
                mem_req  = 1'b1;
                mem_addr = cp_src;
            end
            W_CPWR: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = cp_dst;
            end
            W_RSLT: res_push = rs_en && !res_full;
            default: ;
        endcase
    end

    // R13: an unacknowledged request stays put
    p_req_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));

    // R5: a destination write only follows a completed source read
    p_wr_after_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |-> $past(mem_ack));

    // R7: every pushed result carries the valid flag
    p_res_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        res_push |-> res_word[31]);

endmodule

// File: rtl/dma_list_chan.sv
module dma_list_chan
    import dma_list_pkg::*;
#(
    parameter int MEM_AW    = 16,
    parameter int CMD_DEPTH = 2,
    parameter int RES_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata
);
    localparam int CMD_CW = $clog2(CMD_DEPTH+1);
    localparam int RES_CW = $clog2(RES_DEPTH+1);

    logic [2:0]        cfg;
    logic              cmd_push, cmd_pop, cmd_full, cmd_empty;
    logic [31:0]       cmd_word;
    logic [CMD_CW-1:0] cmd_cnt;
    logic              res_push, res_pop, res_full, res_empty;
    logic [31:0]       res_in, res_head;
    logic [RES_CW-1:0] res_cnt;
    logic              flush_wr;
    logic [31:0]       status;

    assign cmd_push = reg_wr && (reg_addr == OFS_CMD) && !cmd_full;
    assign flush_wr = reg_wr && (reg_addr == OFS_FLUSH);
    assign res_pop  = reg_rd && (reg_addr == OFS_RES) && !res_empty;
    assign irq      = cfg[0] && !res_empty;
    assign status   = {3'(res_cnt), 2'(cmd_cnt), 25'd0, !res_empty, !cmd_full};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                cfg <= '0;
        else if (reg_wr && reg_addr == OFS_CFG)    cfg <= reg_wdata[2:0];
    end

    always_comb begin
        unique case (reg_addr)
            OFS_RES:  reg_rdata = res_empty ? 32'd0 : res_head;
            OFS_STAT: reg_rdata = status;
            OFS_CFG:  reg_rdata = {29'd0, cfg};
            default:  reg_rdata = 32'd0;
        endcase
    end

    dma_fifo #(.W(32), .DEPTH(CMD_DEPTH)) u_cmdq (
        .clk(clk), .rst_n(rst_n),
        .push(cmd_push), .din(reg_wdata),
        .pop(cmd_pop), .dout(cmd_word),
        .full(cmd_full), .empty(cmd_empty), .count(cmd_cnt)
    );

    dma_fifo #(.W(32), .DEPTH(RES_DEPTH)) u_resq (
        .clk(clk), .rst_n(rst_n),
        .push(res_push), .din(res_in),
        .pop(res_pop), .dout(res_head),
        .full(res_full), .empty(res_empty), .count(res_cnt)
    );

    dma_walker #(.MEM_AW(MEM_AW)) u_walk (
        .clk(clk), .rst_n(rst_n),
        .cmd_empty(cmd_empty), .cmd_word(cmd_word), .cmd_pop(cmd_pop),
        .res_full(res_full), .res_push(res_push), .res_word(res_in),
        .res_cfg(cfg[2:1]), .flush_wr(flush_wr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // R9: reading an empty result queue leaves it empty
    p_empty_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == OFS_RES && res_empty && !res_push) |=> res_empty);

    // R10: a command that arrives with the queue full is not stored
    p_cmd_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_CMD && cmd_full && !cmd_pop) |=> cmd_full);

endmodule

// File: tb/dma_list_chan_test.sv
module dma_list_chan_test;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          irq;
    logic          mem_req, mem_we, mem_ack = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata, mem_rdata = '0;

    logic [31:0] mem [0:1023];
    int nchk = 0, nbad = 0;
    int wait_cnt = 0, lat = 0, seq = 0;

    always #2.5 clk = ~clk;

    dma_list_chan #(.MEM_AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // memory model: 0..2 cycle latency, decided away from the rising edge
    always @(negedge clk) begin
        mem_ack = 1'b0;
        if (mem_req) begin
            if (wait_cnt >= lat) begin
                mem_ack = 1'b1;
                if (mem_we) mem[mem_addr] = mem_wdata;
                else        mem_rdata = mem[mem_addr];
                wait_cnt = 0;
                seq++;
                lat = seq % 3;
            end else begin
                wait_cnt++;
            end
        end
    end

    function automatic logic [31:0] pat(int i);
        return 32'hC0DE_0000 | 32'(i);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic init_mem();
        for (int i = 0; i < 1024; i++) mem[i] = pat(i);
    endtask

    task automatic put_ptr(input int w, input int tgt, input logic last);
        mem[w] = {last, 2'b00, 29'(tgt >> 1)};
    endtask

    task automatic put_desc(input int w, input logic [31:0] c, input int sw, input int dw, input int len);
        mem[w]   = c;
        mem[w+1] = 32'(sw * 4);
        mem[w+2] = 32'(dw * 4);
        mem[w+3] = 32'(len);
    endtask

    task automatic start(input int list_w);
        wr(3'd0, {3'd1, 29'(list_w >> 1)});
    endtask

    task automatic wait_count(input int n);
        logic [31:0] s;
        int k;
        k = 0;
        rd(3'd2, s);
        while (32'(s[31:29]) != 32'(n) && k < 3000) begin
            rd(3'd2, s);
            k++;
        end
    endtask

    task automatic check_copy(input string req, input int sw, input int dw, input int len);
        int nw;
        nw = (len + 3) / 4;
        for (int k = 0; k < nw; k++) check(req, mem[dw+k], pat(sw+k));
        check(req, mem[dw+nw], pat(dw+nw));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nbad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        init_mem();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(3'd2, v); check("R1 status", v, 32'h0000_0001);
        rd(3'd1, v); check("R1 empty result", v, 32'h0);
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 no request", {31'd0, mem_req}, 32'd0);

        // R2 R3 R4 R5 R7: length sweep, one entry, one descriptor
        wr(3'd3, 32'd4);
        for (int len = 0; len < 10; len++) begin
            init_mem();
            put_ptr(32'h40, 32'h80, 1'b1);
            put_desc(32'h80, 32'h8000_0000, 32'h200 + len, 32'h300, len);
            start(32'h40);
            wait_count(1);
            rd(3'd1, v); check("R7 done result", v, 32'h8000_0002);
            check_copy("R5 copy length", 32'h200 + len, 32'h300, len);
        end

        // R3 R4: two table entries, two descriptors in the first array
        init_mem();
        put_ptr(32'h40, 32'h80, 1'b0);
        put_ptr(32'h41, 32'hC0, 1'b1);
        put_desc(32'h80, 32'h0, 32'h200, 32'h300, 8);
        put_desc(32'h84, 32'h8000_0000, 32'h210, 32'h310, 5);
        put_desc(32'hC0, 32'h8000_0000, 32'h220, 32'h320, 12);
        start(32'h40);
        wait_count(1);
        rd(3'd1, v); check("R3 two-level done", v, 32'h8000_0002);
        check_copy("R4 desc 0", 32'h200, 32'h300, 8);
        check_copy("R4 desc 1", 32'h210, 32'h310, 5);
        check_copy("R3 second entry", 32'h220, 32'h320, 12);

        // R6: bad descriptor modes end the walk after earlier copies
        for (int m = 1; m < 4; m++) begin
            init_mem();
            put_ptr(32'h40, 32'h80, 1'b1);
            put_desc(32'h80, 32'h0, 32'h200, 32'h300, 4);
            put_desc(32'h84, 32'h8000_0000 | 32'(m), 32'h210, 32'h310, 4);
            start(32'h40);
            wait_count(1);
            rd(3'd1, v); check("R6 desc mode error", v, 32'h8000_0008);
            check_copy("R6 first copy kept", 32'h200, 32'h300, 4);
            check("R6 no copy after error", mem[32'h310], pat(32'h310));
        end

        // R6: command kinds other than 1, configuration all clear
        wr(3'd3, 32'd0);
        init_mem();
        put_ptr(32'h40, 32'h80, 1'b1);
        put_desc(32'h80, 32'h8000_0000, 32'h200, 32'h300, 4);
        for (int c = 0; c < 8; c++) begin
            if (c != 1) begin
                wr(3'd0, {3'(c), 29'h20});
                wait_count(1);
                rd(3'd1, v); check("R6 command kind error", v, 32'h8000_0008);
            end
        end
        check("R6 no memory access", mem[32'h300], pat(32'h300));

        // R7: completion with bit 2 clear pushes nothing
        start(32'h40);
        repeat (300) @(negedge clk);
        rd(3'd2, v); check("R7 no result", v, 32'h0000_0001);
        check_copy("R7 copy still done", 32'h200, 32'h300, 4);

        // R10 R12 R9: fill the result queue, stall, queue commands, drain
        wr(3'd3, 32'd4);
        for (int i = 0; i < 4; i++) begin
            start(32'h40);
            wait_count(i + 1);
        end
        rd(3'd2, v); check("R10 four results", v, 32'h8000_0003);
        start(32'h40);
        repeat (100) @(negedge clk);
        rd(3'd2, v); check("R12 stalled walker", v, 32'h8000_0003);
        start(32'h40);
        start(32'h40);
        rd(3'd2, v); check("R10 command queue full", v, 32'h9000_0002);
        start(32'h40);
        rd(3'd2, v); check("R10 extra command dropped", v, 32'h9000_0002);
        for (int j = 0; j < 7; j++) begin
            repeat (100) @(negedge clk);
            rd(3'd1, v); check("R12 no result lost", v, 32'h8000_0002);
        end
        repeat (100) @(negedge clk);
        rd(3'd1, v); check("R9 drained queue reads 0", v, 32'h0);
        rd(3'd2, v); check("R9 empty status", v, 32'h0000_0001);

        // R8: flush with its result enabled
        wr(3'd3, 32'd6);
        init_mem();
        put_ptr(32'h40, 32'h80, 1'b1);
        put_desc(32'h80, 32'h0, 32'h200, 32'h300, 32);
        put_desc(32'h84, 32'h0, 32'h210, 32'h310, 32);
        put_desc(32'h88, 32'h8000_0000, 32'h220, 32'h320, 32);
        start(32'h40);
        wr(3'd4, 32'd0);
        wait_count(1);
        rd(3'd1, v); check("R8 flush result", v, 32'h8000_0004);
        check_copy("R8 current desc finished", 32'h200, 32'h300, 32);
        check("R8 next desc skipped", mem[32'h310], pat(32'h310));
        check("R8 last desc skipped", mem[32'h320], pat(32'h320));

        // R8: flush with its result disabled
        wr(3'd3, 32'd4);
        init_mem();
        put_ptr(32'h40, 32'h80, 1'b1);
        put_desc(32'h80, 32'h0, 32'h200, 32'h300, 32);
        put_desc(32'h84, 32'h8000_0000, 32'h210, 32'h310, 32);
        start(32'h40);
        wr(3'd4, 32'd0);
        repeat (400) @(negedge clk);
        rd(3'd2, v); check("R8 silent flush", v, 32'h0000_0001);
        check("R8 silent flush skip", mem[32'h310], pat(32'h310));

        // R11: interrupt follows enable and queue state
        wr(3'd3, 32'd5);
        check("R11 irq empty", {31'd0, irq}, 32'd0);
        start(32'h40);
        wait_count(1);
        #1 check("R11 irq set", {31'd0, irq}, 32'd1);
        wr(3'd3, 32'd4);
        #1 check("R11 irq masked", {31'd0, irq}, 32'd0);
        wr(3'd3, 32'd5);
        #1 check("R11 irq unmasked", {31'd0, irq}, 32'd1);
        rd(3'd1, v);
        #1 check("R11 irq cleared by pop", {31'd0, irq}, 32'd0);

        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

endmodule